// File: doc/BRIEF.md
# Switching Clock Source Selector with Stall Fallback

This block picks the clock enable that paces a switching regulator's power stage. Two candidates exist: a tick from an internal free-running oscillator, and an external synchronisation input that arrives without any relation to the reference clock. The external input is brought into the reference domain, its edges are found, and the time between its rising edges is counted in reference cycles. The block hands pacing over to the external source only after it has shown a short run of periods that sit inside an acceptance window. The window is derived from a period limit that corresponds to the programmed internal frequency, and it is also bounded by absolute frequency limits.

When an accepted external clock stops toggling, the block stops the power-switch drive at once. The drive stays off until an external edge comes back. If the silence lasts for the full timeout, pacing returns to the internal oscillator and the drive resumes. A later, well-behaved external clock is accepted again after it requalifies. A status flag shows which source currently owns the switching clock.

Top module: `sync_clk_sel`

## Requirements
- R1: While the external source is active, `clk_en` pulses exactly once per rising edge of `sync_in`, and `int_tick` has no effect on it.
- R2: Switchover to the external source needs QUAL_EDGES (default 2) consecutive in-window periods. After only one such period the block still reports the internal source.
- R3: An external period P, measured in reference cycles, is in-window only if `per_limit`/2 < P < `per_limit`. Periods of 120 or 40 against a `per_limit` of 100 never cause a switchover.
- R4: A period shorter than CEIL_MIN_PER (default 46, the absolute frequency ceiling) is rejected. When `per_limit` exceeds FLOOR_MAX_PER (default 555, the internal frequency floor), every external period is rejected.
- R5: If `sync_in` shows no transition for TIMEOUT_CYC reference cycles (default 3200) while the external source is active or held, `src_ext` returns to 0.
- R6: While the external source is active, a gap with no `sync_in` transition that exceeds `per_limit` cycles drives `drv_en` low and stops `clk_en` pulses. A returning rising edge restores `drv_en` high and keeps the external source selected.
- R7: After a timeout fallback, `drv_en` is high and `clk_en` follows `int_tick`. A valid external clock that returns is selected again after requalification.
- R8: After reset, `src_ext` is 0 (internal) and `drv_en` is 1.
- R9: While the internal source is active, `clk_en` pulses once per `int_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | External synchronisation clock, asynchronous |
| int_tick | input | 1 | One-cycle tick from the internal oscillator |
| per_limit | input | CNT_W | Internal oscillator period in reference cycles |
| clk_en | output | 1 | Selected switching clock enable, one cycle per switching period |
| drv_en | output | 1 | Power-switch drive permitted |
| src_ext | output | 1 | 1 when the external source owns the switching clock (active or held) |

## Verification
A wrong qualification count or window comparison shows up on `src_ext`. The flag changes one period too early or too late, or it rises for a period outside the window. This is visible within a few external periods of the stimulus starting. A wrong gap or timeout comparison shows up on `drv_en` within about `per_limit` cycles of the clock stopping, or on `src_ext` near the end of the timeout. A wrong source mux shows up in the `clk_en` pulse count over a window whose length is a multiple of both candidate periods.

// File: rtl/scs_pkg.sv
package scs_pkg;
   typedef enum logic [1:0] {
      SRC_INT  = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_HOLD = 2'd2
   } src_state_e;
endpackage

// File: rtl/scs_edge_det.sv
module scs_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise,
   output logic any_edge
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scs_edge_det: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= async_in;
            else chain[i] <= chain[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise     = chain[STAGES-1] & ~last_q;
   assign any_edge = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/scs_period_mon.sv
module scs_period_mon #(
   parameter int CNT_W         = 12,
   parameter int CEIL_MIN_PER  = 46,
   parameter int FLOOR_MAX_PER = 555,
   parameter int TIMEOUT_CYC   = 3200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             any_edge,
   input  logic [CNT_W-1:0] per_limit,
   output logic             per_vld,
   output logic             per_ok,
   output logic             gap_stall,
   output logic             timeout,
   output logic [CNT_W-1:0] idle_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CEIL_P  = CNT_W'(CEIL_MIN_PER);
   localparam logic [CNT_W-1:0] FLOOR_P = CNT_W'(FLOOR_MAX_PER);
   localparam logic [CNT_W-1:0] TMO_P   = CNT_W'(TIMEOUT_CYC);

   generate
      if (TIMEOUT_CYC >= (1 << CNT_W) - 1) begin : g_bad_tmo
         $error("scs_period_mon: TIMEOUT_CYC does not fit in CNT_W");
      end
      if (CEIL_MIN_PER < 2) begin : g_bad_ceil
         $error("scs_period_mon: CEIL_MIN_PER must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] per_q;
   logic             have_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt   <= '0;
         per_q     <= '0;
         per_vld   <= 1'b0;
         have_prev <= 1'b0;
      end else begin
         per_vld <= 1'b0;
         if (rise) begin
            per_q     <= run_cnt;
            per_vld   <= have_prev;
            have_prev <= 1'b1;
            run_cnt   <= CNT_W'(1);
         end else begin
            if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
            if (gap_stall) have_prev <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              idle_cnt <= '0;
      else if (any_edge)       idle_cnt <= '0;
      else if (idle_cnt != CNT_MAX) idle_cnt <= idle_cnt + 1'b1;
   end

   assign per_ok = (per_q > {1'b0, per_limit[CNT_W-1:1]}) &&
                   (per_q < per_limit) &&
                   (per_q >= CEIL_P) &&
                   (per_limit <= FLOOR_P);
   assign gap_stall = idle_cnt > per_limit;
   assign timeout   = idle_cnt >= TMO_P;

   // R3: a period taken as in-window lies strictly inside the relative window
   a_r3_window_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (per_vld && per_ok) |-> (per_q < per_limit && (per_q << 1) > per_limit));
   // R4: no accepted period violates the absolute ceiling or the floor
   a_r4_absolute_limits: assert property (@(posedge clk) disable iff (!rst_n)
      (per_vld && per_ok) |-> (per_q >= CEIL_P && per_limit <= FLOOR_P));
endmodule

// File: rtl/scs_src_fsm.sv
module scs_src_fsm
   import scs_pkg::*;
#(
   parameter int QUAL_EDGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rise,
   input  logic       per_vld,
   input  logic       per_ok,
   input  logic       gap_stall,
   input  logic       timeout,
   output src_state_e state
);
   localparam int QW = (QUAL_EDGES < 2) ? 1 : $clog2(QUAL_EDGES + 1);

   generate
      if (QUAL_EDGES < 1) begin : g_bad_qual
         $error("scs_src_fsm: QUAL_EDGES must be at least 1");
      end
   endgenerate

   logic [QW-1:0] qual_cnt;
   logic          qual_done;

   assign qual_done = (qual_cnt == QW'(QUAL_EDGES - 1)) && per_vld && per_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SRC_INT;
         qual_cnt <= '0;
      end else begin
         unique case (state)
            SRC_INT: begin
               if (qual_done) begin
                  state    <= SRC_EXT;
                  qual_cnt <= '0;
               end else if (per_vld) begin
                  qual_cnt <= per_ok ? qual_cnt + 1'b1 : '0;
               end else if (gap_stall) begin
                  qual_cnt <= '0;
               end
            end
            SRC_EXT: begin
               if (gap_stall) state <= SRC_HOLD;
            end
            SRC_HOLD: begin
               if (timeout)   state <= SRC_INT;
               else if (rise) state <= SRC_EXT;
            end
            default: state <= SRC_INT;
         endcase
      end
   end

   // R2: entering the external source requires the full run of good periods
   a_r2_qualified_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == SRC_INT && state == SRC_EXT) |->
         ($past(qual_cnt) == QW'(QUAL_EDGES - 1) && $past(per_ok)));
   // R5: the held state is always left once the timeout is reached
   a_r5_timeout_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SRC_HOLD && timeout) |=> state == SRC_INT);
endmodule

// File: rtl/sync_clk_sel.sv
module sync_clk_sel
   import scs_pkg::*;
#(
   parameter int CNT_W         = 12,
   parameter int SYNC_STAGES   = 2,
   parameter int QUAL_EDGES    = 2,
   parameter int CEIL_MIN_PER  = 46,
   parameter int FLOOR_MAX_PER = 555,
   parameter int TIMEOUT_CYC   = 3200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_in,
   input  logic             int_tick,
   input  logic [CNT_W-1:0] per_limit,
   output logic             clk_en,
   output logic             drv_en,
   output logic             src_ext
);
   logic             rise;
   logic             any_edge;
   logic             per_vld;
   logic             per_ok;
   logic             gap_stall;
   logic             timeout;
   logic [CNT_W-1:0] idle_cnt;
   src_state_e       state;

   scs_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sync_in),
      .rise     (rise),
      .any_edge (any_edge)
   );

   scs_period_mon #(
      .CNT_W         (CNT_W),
      .CEIL_MIN_PER  (CEIL_MIN_PER),
      .FLOOR_MAX_PER (FLOOR_MAX_PER),
      .TIMEOUT_CYC   (TIMEOUT_CYC)
   ) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise),
      .any_edge  (any_edge),
      .per_limit (per_limit),
      .per_vld   (per_vld),
      .per_ok    (per_ok),
      .gap_stall (gap_stall),
      .timeout   (timeout),
      .idle_cnt  (idle_cnt)
   );

   scs_src_fsm #(.QUAL_EDGES(QUAL_EDGES)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise),
      .per_vld   (per_vld),
      .per_ok    (per_ok),
      .gap_stall (gap_stall),
      .timeout   (timeout),
      .state     (state)
   );

   always_comb begin
      unique case (state)
         SRC_EXT:  clk_en = rise;
         SRC_HOLD: clk_en = 1'b0;
         default:  clk_en = int_tick;
      endcase
   end

   assign drv_en  = (state != SRC_HOLD);
   assign src_ext = (state != SRC_INT);

   // R1: external pacing only ever comes from a detected rising edge
   a_r1_ext_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SRC_EXT && clk_en) |-> rise);
   // R6: no switching clock while the drive is withheld
   a_r6_no_pulse_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en |-> !clk_en);
   // R5: the held state never outlasts the silence timeout
   a_r5_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SRC_HOLD) |-> idle_cnt <= CNT_W'(TIMEOUT_CYC));
   // R8: the internal source always runs with the drive enabled
   a_r8_internal_drives: assert property (@(posedge clk) disable iff (!rst_n)
      !src_ext |-> drv_en);
endmodule

// File: tb/sync_clk_sel_tb.sv
module sync_clk_sel_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 12;
   localparam int TICK_PER   = 100;
   localparam int WATCHDOG   = 150000;

   typedef struct {
      int    kind;   // 0: src_ext, 1: drv_en, 2: running clk_en pulse total
      int    exp;
      string req;
   } sb_item_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sync_in = 1'b0;
   logic             int_tick = 1'b0;
   logic [CNT_W-1:0] per_limit = CNT_W'(100);
   logic             clk_en;
   logic             drv_en;
   logic             src_ext;

   sb_item_t sb_q[$];
   int  n_cmp = 0;
   int  n_bad = 0;
   int  pulse_total = 0;
   int  ext_half = 40;
   bit  ext_run = 1'b0;
   bit  done = 1'b0;

   sync_clk_sel u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (sync_in),
      .int_tick  (int_tick),
      .per_limit (per_limit),
      .clk_en    (clk_en),
      .drv_en    (drv_en),
      .src_ext   (src_ext)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // external clock generator, 50% duty, period 2*ext_half cycles
   initial begin
      int hc;
      hc = 0;
      forever begin
         @(posedge clk); #2;
         if (ext_run) begin
            if (hc >= ext_half - 1) begin
               sync_in = ~sync_in;
               hc = 0;
            end else hc++;
         end
      end
   end

   // internal oscillator tick, one cycle every TICK_PER cycles
   initial begin
      int tc;
      tc = 0;
      forever begin
         @(posedge clk); #2;
         int_tick = (tc == TICK_PER - 1);
         tc = (tc == TICK_PER - 1) ? 0 : tc + 1;
      end
   end

   // monitor: compare pending items, then accumulate this cycle's pulse
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            sb_item_t it;
            int act;
            it = sb_q.pop_front();
            act = (it.kind == 0) ? int'(src_ext) :
                  (it.kind == 1) ? int'(drv_en) : pulse_total;
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s kind=%0d actual=%0d expected=%0d",
                        it.req, it.kind, act, it.exp);
            end
         end
         if (rst_n && clk_en) pulse_total++;
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
      end
   endtask

   task automatic push(input int kind, input int exp, input string req);
      sb_item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.req  = req;
      sb_q.push_back(it);
   endtask

   task automatic expect_pulses(input int cycles, input int n, input string req);
      int base;
      base = pulse_total;
      tick(cycles);
      push(2, base + n, req);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(2);
      push(0, 0, "R8"); push(1, 1, "R8");
      // R9: internal pacing
      expect_pulses(1000, 10, "R9");
      // R2: qualification with period 80 against limit 100
      ext_half = 40; ext_run = 1'b1;
      tick(150);
      push(0, 0, "R2");
      tick(170);
      push(0, 1, "R2");
      tick(100);
      // R1: external pacing, 10 pulses in 800 cycles (internal would give 8)
      expect_pulses(800, 10, "R1");
      // R6: brief stall holds drive off, returning edge restores it
      ext_run = 1'b0;
      tick(300);
      push(1, 0, "R6"); push(0, 1, "R6");
      expect_pulses(200, 0, "R6");
      ext_run = 1'b1;
      tick(200);
      push(1, 1, "R6"); push(0, 1, "R6");
      // R5: long stall times out to internal
      ext_run = 1'b0;
      tick(2900);
      push(1, 0, "R6");
      tick(500);
      push(0, 0, "R5"); push(1, 1, "R7");
      expect_pulses(1000, 10, "R7");
      ext_run = 1'b1;
      tick(400);
      push(0, 1, "R7");
      // return to internal before window tests
      ext_run = 1'b0;
      tick(3600);
      push(0, 0, "R5");
      // R3: too slow (120) and too fast (40)
      ext_half = 60; ext_run = 1'b1;
      tick(1000);
      push(0, 0, "R3");
      ext_run = 1'b0; tick(200);
      ext_half = 20; ext_run = 1'b1;
      tick(1000);
      push(0, 0, "R3");
      // R4: ceiling, period 44 against limit 80
      ext_run = 1'b0; tick(200);
      per_limit = CNT_W'(80);
      ext_half = 22; ext_run = 1'b1;
      tick(1000);
      push(0, 0, "R4");
      // R4: floor, limit 600 rejects period 400
      ext_run = 1'b0; tick(200);
      per_limit = CNT_W'(600);
      ext_half = 200; ext_run = 1'b1;
      tick(2000);
      push(0, 0, "R4");
      // R3: in-window period accepted again
      ext_run = 1'b0; tick(800);
      per_limit = CNT_W'(100);
      ext_half = 40; ext_run = 1'b1;
      tick(400);
      push(0, 1, "R3");
      tick(3);
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
      end
      @(negedge clk); @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule